// File: doc/BRIEF.md
# Colour Lookup Table Host Port

This block gives a host processor byte-wide register access to a 256-entry RGB colour lookup table and to a small cursor palette. The host sets an index through one of two index ports: one for reads, one for writes. It then moves a colour through a single shared data port as three back-to-back accesses, first red, then green, then blue. A shared phase counter tracks which component comes next. Red and green writes are held in staging registers, and the whole 24-bit entry is written to the table on the blue write. When an entry is complete, the matching index moves on by one, so a run of entries streams without the index being set again.

The `cur_sel` input sends the data port to a two-entry cursor palette instead of the main table. In this mode the index never steps. The same input also decides whether port 0 reaches the pixel mask register or the converter command register.

Top module: `clut_port`

## Requirements
- R1: After reset the read index, write index and component phase are 0 (red). The pixel mask is 0xFF, the command register is 0x00, `bus_rdata` is 0x00 and both cursor entries are 0.
- R2: Address map on `bus_addr`: 0 = mask/command, 1 = read index, 2 = write index, 3 = data. A read of 1 or 2 returns the current index. `bus_rdata` is registered: it takes the read value on the clock edge that samples `bus_re` and holds it until the next read.
- R3: Data writes fill red, green and blue in that order. An entry packs as {red[23:16], green[15:8], blue[7:0]}. The table entry changes only on the blue write, and a triple that is cut short leaves the entry unchanged.
- R4: After a blue write in main mode the write index increments, wrapping from 255 to 0.
- R5: Three data reads return red, green, then blue of the entry at the read index. After the blue read the read index increments, wrapping from 255 to 0.
- R6: A write to either index port returns the phase to red and drops any staged red and green.
- R7: With `cur_sel`=1, data accesses use cursor entry index[0]. Neither index steps, and the main table is not touched.
- R8: At address 0, `cur_sel`=0 selects the pixel mask and `cur_sel`=1 selects the command register, for both reads and writes.
- R9: Data reads and data writes advance one shared phase counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cur_sel | input | 1 | 1: cursor palette and command register; 0: main table and pixel mask |
| bus_we | input | 1 | Write strobe (takes priority over bus_re) |
| bus_re | input | 1 | Read strobe |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |

## Verification
The hard cases to reach from the ports are an index crossing 255 to 0 in the middle of a stream, and a triple abandoned after red and green while an old entry must still read back. The stimulus first fills the whole table through one long auto-stepped write stream. It then places the read index just below the wrap, and finally cuts a triple short with an index write before reading the entry. Random traffic with a fixed seed then mixes data reads with data writes, so the shared phase is seen from both sides. It also flips `cur_sel` partway through a triple.

// File: rtl/clut_pkg.sv
package clut_pkg;
  localparam int COMP_W = 8;
  localparam int RGB_W  = 3 * COMP_W;

  typedef enum logic [1:0] {PH_RED = 2'd0, PH_GRN = 2'd1, PH_BLU = 2'd2} phase_e;

  localparam logic [1:0] ADR_MASK = 2'd0;
  localparam logic [1:0] ADR_RIDX = 2'd1;
  localparam logic [1:0] ADR_WIDX = 2'd2;
  localparam logic [1:0] ADR_DATA = 2'd3;

  function automatic phase_e phase_after(phase_e p);
    case (p)
      PH_RED:  return PH_GRN;
      PH_GRN:  return PH_BLU;
      default: return PH_RED;
    endcase
  endfunction

  function automatic logic [COMP_W-1:0] pick_comp(logic [RGB_W-1:0] rgb, phase_e p);
    case (p)
      PH_RED:  return rgb[3*COMP_W-1:2*COMP_W];
      PH_GRN:  return rgb[2*COMP_W-1:COMP_W];
      default: return rgb[COMP_W-1:0];
    endcase
  endfunction
endpackage

// File: rtl/clut_seq.sv
module clut_seq
  import clut_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cur_sel,
  input  logic              ld_ridx,
  input  logic              ld_widx,
  input  logic              dat_wr,
  input  logic              dat_rd,
  input  logic [COMP_W-1:0] wdata,
  output phase_e            phase,
  output logic [IDX_W-1:0]  rd_idx,
  output logic [IDX_W-1:0]  wr_idx,
  output logic              commit_ev,
  output logic [RGB_W-1:0]  commit_rgb
);
  logic [COMP_W-1:0] hold_r, hold_g;
  logic              rd_step_ev, wr_step_ev;

  assign commit_ev  = dat_wr && (phase == PH_BLU);
  assign wr_step_ev = commit_ev && !cur_sel;
  assign rd_step_ev = dat_rd && (phase == PH_BLU) && !cur_sel;
  assign commit_rgb = {hold_r, hold_g, wdata};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase  <= PH_RED;
      rd_idx <= '0;
      wr_idx <= '0;
      hold_r <= '0;
      hold_g <= '0;
    end else if (ld_ridx) begin
      rd_idx <= IDX_W'(wdata);
      phase  <= PH_RED;
    end else if (ld_widx) begin
      wr_idx <= IDX_W'(wdata);
      phase  <= PH_RED;
    end else if (dat_wr) begin
      if (phase == PH_RED) hold_r <= wdata;
      if (phase == PH_GRN) hold_g <= wdata;
      phase <= phase_after(phase);
      if (wr_step_ev) wr_idx <= wr_idx + IDX_W'(1);
    end else if (dat_rd) begin
      phase <= phase_after(phase);
      if (rd_step_ev) rd_idx <= rd_idx + IDX_W'(1);
    end
  end

  a_r6_index_resets_phase: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_ridx || ld_widx) |=> (phase == PH_RED));
  a_r4_wr_index_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr && !ld_ridx && !ld_widx && phase == PH_BLU && !cur_sel)
      |=> (wr_idx == $past(wr_idx) + IDX_W'(1)));
  a_r5_rd_index_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_rd && !dat_wr && !ld_ridx && !ld_widx && phase == PH_BLU && !cur_sel)
      |=> (rd_idx == $past(rd_idx) + IDX_W'(1)));
  a_r7_cursor_no_step: assert property (@(posedge clk) disable iff (!rst_n)
    ((dat_wr || dat_rd) && !ld_ridx && !ld_widx && cur_sel)
      |=> ($stable(wr_idx) && $stable(rd_idx)));
  a_r9_phase_advances: assert property (@(posedge clk) disable iff (!rst_n)
    ((dat_wr || dat_rd) && !ld_ridx && !ld_widx && phase == PH_RED) |=> (phase == PH_GRN));
  a_r3_phase_legal: assert property (@(posedge clk) disable iff (!rst_n)
    phase != 2'd3);
endmodule

// File: rtl/clut_ram.sv
module clut_ram
  import clut_pkg::*;
#(
  parameter int IDX_W = 8,
  parameter int CUR_N = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_cur,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [RGB_W-1:0] wr_rgb,
  input  logic             rd_cur,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [RGB_W-1:0] rd_rgb
);
  localparam int DEPTH = 1 << IDX_W;
  localparam int CUR_W = (CUR_N > 1) ? $clog2(CUR_N) : 1;

  logic [RGB_W-1:0] tbl [DEPTH];
  logic [RGB_W-1:0] cur_tbl [CUR_N];
  logic [CUR_W-1:0] cur_wsel, cur_rsel;

  assign cur_wsel = CUR_W'(wr_idx);
  assign cur_rsel = CUR_W'(rd_idx);

  always_ff @(posedge clk) begin
    if (wr_en && !wr_cur) tbl[wr_idx] <= wr_rgb;
  end

  for (genvar g = 0; g < CUR_N; g++) begin : g_cur
    always_ff @(posedge clk) begin
      if (!rst_n)                                     cur_tbl[g] <= '0;
      else if (wr_en && wr_cur && cur_wsel == CUR_W'(g)) cur_tbl[g] <= wr_rgb;
    end
  end

  assign rd_rgb = rd_cur ? cur_tbl[cur_rsel] : tbl[rd_idx];
endmodule

// File: rtl/clut_port.sv
module clut_port
  import clut_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cur_sel,
  input  logic       bus_we,
  input  logic       bus_re,
  input  logic [1:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata
);
  localparam int IDX_W = 8;
  localparam int CUR_N = 2;

  logic             rd_strobe;
  logic             ld_ridx, ld_widx, dat_wr, dat_rd;
  phase_e           phase;
  logic [IDX_W-1:0] rd_idx, wr_idx;
  logic             commit_ev;
  logic [RGB_W-1:0] commit_rgb, rd_rgb;
  logic [7:0]       mask_q, cmd_q;

  assign rd_strobe = bus_re && !bus_we;
  assign ld_ridx   = bus_we && bus_addr == ADR_RIDX;
  assign ld_widx   = bus_we && bus_addr == ADR_WIDX;
  assign dat_wr    = bus_we && bus_addr == ADR_DATA;
  assign dat_rd    = rd_strobe && bus_addr == ADR_DATA;

  clut_seq #(.IDX_W(IDX_W)) u_seq (
    .clk, .rst_n, .cur_sel, .ld_ridx, .ld_widx, .dat_wr, .dat_rd,
    .wdata(bus_wdata), .phase, .rd_idx, .wr_idx, .commit_ev, .commit_rgb
  );

  clut_ram #(.IDX_W(IDX_W), .CUR_N(CUR_N)) u_ram (
    .clk, .rst_n, .wr_en(commit_ev), .wr_cur(cur_sel), .wr_idx,
    .wr_rgb(commit_rgb), .rd_cur(cur_sel), .rd_idx, .rd_rgb
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q    <= 8'hFF;
      cmd_q     <= 8'h00;
      bus_rdata <= 8'h00;
    end else begin
      if (bus_we && bus_addr == ADR_MASK) begin
        if (cur_sel) cmd_q  <= bus_wdata;
        else         mask_q <= bus_wdata;
      end
      if (rd_strobe) begin
        case (bus_addr)
          ADR_MASK: bus_rdata <= cur_sel ? cmd_q : mask_q;
          ADR_RIDX: bus_rdata <= 8'(rd_idx);
          ADR_WIDX: bus_rdata <= 8'(wr_idx);
          default:  bus_rdata <= pick_comp(rd_rgb, phase);
        endcase
      end
    end
  end

  a_r2_rdata_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_strobe |=> $stable(bus_rdata));
  a_r8_mask_kept_in_cursor_mode: assert property (@(posedge clk) disable iff (!rst_n)
    cur_sel |=> $stable(mask_q));
  a_r8_cmd_kept_in_main_mode: assert property (@(posedge clk) disable iff (!rst_n)
    !cur_sel |=> $stable(cmd_q));
endmodule

// File: tb/clut_port_tb.sv
module clut_port_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cur_sel = 1'b0;
  logic       bus_we = 1'b0;
  logic       bus_re = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;

  int n_vec = 0;
  int n_bad = 0;

  logic [23:0] m_main [256];
  logic [23:0] m_cur [2];
  logic [7:0]  m_ridx, m_widx, m_r, m_g, m_mask, m_cmd;
  int          m_ph;

  always #(CLK_PERIOD/2) clk = ~clk;

  clut_port u_dut (.clk, .rst_n, .cur_sel, .bus_we, .bus_re, .bus_addr, .bus_wdata, .bus_rdata);

  function automatic logic [7:0] comp_of(logic [23:0] rgb, int ph);
    logic [23:0] sh;
    sh = rgb >> (8 * (2 - ph));
    return sh[7:0];
  endfunction

  function automatic logic [23:0] pattern(int i);
    logic [31:0] v;
    v = (i * 32'h9E3779B1) ^ 32'h5A5A5A;
    return v[23:0];
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic bus_write(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
    case (a)
      2'd0: if (cur_sel) m_cmd = d; else m_mask = d;
      2'd1: begin m_ridx = d; m_ph = 0; end
      2'd2: begin m_widx = d; m_ph = 0; end
      default: begin
        if (m_ph == 0) m_r = d;
        else if (m_ph == 1) m_g = d;
        else begin
          if (cur_sel) m_cur[m_widx[0]] = {m_r, m_g, d};
          else begin m_main[m_widx] = {m_r, m_g, d}; m_widx = m_widx + 8'd1; end
        end
        m_ph = (m_ph + 1) % 3;
      end
    endcase
  endtask

  task automatic bus_read_chk(logic [1:0] a, string req);
    logic [7:0] exp;
    case (a)
      2'd0: exp = cur_sel ? m_cmd : m_mask;
      2'd1: exp = m_ridx;
      2'd2: exp = m_widx;
      default: begin
        exp = comp_of(cur_sel ? m_cur[m_ridx[0]] : m_main[m_ridx], m_ph);
        if (m_ph == 2 && !cur_sel) m_ridx = m_ridx + 8'd1;
        m_ph = (m_ph + 1) % 3;
      end
    endcase
    @(negedge clk);
    bus_re = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_re = 1'b0;
    check(req, bus_rdata, exp);
  endtask

  task automatic set_mode(logic c);
    @(negedge clk);
    cur_sel = c;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] seed;
    m_ridx = 0; m_widx = 0; m_r = 0; m_g = 0; m_mask = 8'hFF; m_cmd = 0; m_ph = 0;
    m_cur[0] = 0; m_cur[1] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check("R1 rdata", bus_rdata, 8'h00);
    bus_read_chk(2'd1, "R1 ridx");
    bus_read_chk(2'd2, "R1 widx");
    bus_read_chk(2'd0, "R1 mask");
    set_mode(1'b1);
    bus_read_chk(2'd0, "R1 cmd");
    bus_read_chk(2'd3, "R1 cursor0");
    bus_read_chk(2'd1, "R1 ridx");
    set_mode(1'b0);
    // R3 R4: fill the table in one stream; write index wraps back to 0
    bus_write(2'd2, 8'd0);
    for (int i = 0; i < 256; i++) begin
      logic [23:0] p;
      p = pattern(i);
      bus_write(2'd3, p[23:16]);
      bus_write(2'd3, p[15:8]);
      bus_write(2'd3, p[7:0]);
    end
    bus_read_chk(2'd2, "R4 widx wrap");
    // R5: read across the 255 -> 0 boundary
    bus_write(2'd1, 8'd253);
    for (int k = 0; k < 15; k++) bus_read_chk(2'd3, "R5 read stream");
    bus_read_chk(2'd1, "R5 ridx wrap");
    // R3 R6: abandoned triple leaves entry unchanged
    bus_write(2'd2, 8'd5);
    bus_write(2'd3, 8'h11);
    bus_write(2'd3, 8'h22);
    bus_write(2'd1, 8'd5);
    for (int k = 0; k < 3; k++) bus_read_chk(2'd3, "R3 R6 partial dropped");
    bus_read_chk(2'd2, "R6 widx kept");
    // R9: shared phase between write and read
    bus_write(2'd2, 8'd20);
    bus_write(2'd1, 8'd40);
    bus_write(2'd3, 8'hA5);
    bus_read_chk(2'd3, "R9 read picks green");
    // R7: cursor palette, no stepping, main table untouched
    set_mode(1'b1);
    bus_write(2'd2, 8'd3);
    bus_write(2'd3, 8'h12); bus_write(2'd3, 8'h34); bus_write(2'd3, 8'h56);
    bus_read_chk(2'd2, "R7 widx held");
    bus_write(2'd1, 8'd1);
    for (int k = 0; k < 6; k++) bus_read_chk(2'd3, "R7 cursor read");
    bus_read_chk(2'd1, "R7 ridx held");
    // R8: mask/command share address 0
    bus_write(2'd0, 8'h3C);
    bus_read_chk(2'd0, "R8 cmd");
    set_mode(1'b0);
    bus_read_chk(2'd0, "R8 mask untouched");
    bus_write(2'd0, 8'hC3);
    bus_read_chk(2'd0, "R8 mask");
    bus_write(2'd1, 8'd3);
    for (int k = 0; k < 3; k++) bus_read_chk(2'd3, "R7 main untouched");
    // Random mixed traffic
    seed = 32'd12345;
    void'($urandom(seed));
    for (int n = 0; n < 4000; n++) begin
      int op;
      op = $urandom_range(0, 11);
      case (op)
        0: bus_write(2'd1, 8'($urandom));
        1: bus_write(2'd2, 8'($urandom));
        2, 3, 4: bus_write(2'd3, 8'($urandom));
        5, 6, 7: bus_read_chk(2'd3, "R3 R5 R9 random data");
        8: bus_read_chk(2'($urandom_range(1, 2)), "R2 random index");
        9: set_mode(($urandom_range(0, 7) == 0) ? 1'b1 : 1'b0);
        10: bus_write(2'd0, 8'($urandom));
        default: bus_read_chk(2'd0, "R8 random mask/cmd");
      endcase
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule